// File: doc/BRIEF.md
# Shared Instruction and FIFO Store

This block is a 128-location storage array that serves two purposes. The low addresses hold routines written by a host, and an execution engine reads them back. The high addresses can act as a first-in-first-out queue for data that moves between routines and the host. Each location is a 20-bit entry: a 16-bit word plus four control bits.

The host sees a small register window. One register reaches the store itself. Each location needs two 16-bit host cycles: the first moves the word and the second moves the control bits. An internal pointer then steps to the next location, so a host can stream through memory with no address traffic.

The queue starts at the top address and grows downward to a programmable limit. Its full and empty flags can be set to trip one entry early, which leaves margin against overflow and underflow. Pushes and pops refused by the flags have no effect. An execution read port returns a whole entry, one cycle after the request.

Top module: `instr_store_buf`

## Requirements
- R1: After reset the pointer is 0 and the half-select phase is 0. The queue limit is 0x60 with both early modes off. `fifo_empty`=1, `fifo_full`=0, `hst_rvalid`=0 and `ex_valid`=0.
- R2: An entry is 20 bits: [15:0] word, [18:16] level bits, [19] S bit. An execution read (`ex_rd` with `ex_addr`) returns the whole entry on `ex_data`, with `ex_valid`=1, in the following cycle.
- R3: `hst_reg` selects the register: 0 = store window, 1 = pointer, 2 = queue control, 3 = unused (reads 0, writes have no effect). A host read (`hst_en`=1, `hst_we`=0) returns data on `hst_rdata` with `hst_rvalid`=1 one cycle later.
- R4: A store-window access with phase 0 moves the 16-bit word of the location at the pointer, and the phase becomes 1. An access with phase 1 moves the control bits on data bits [3:0] of the same location; on a read, bits [15:4] are 0. The pointer then advances by 1, wrapping from 127 to 0. The pointer never moves after a phase-0 access.
- R5: A pointer read returns the phase in bit 15, zeros in bits [14:7] and the pointer in bits [6:0]. A pointer write loads bits [6:0] and clears the phase to 0.
- R6: Queue control layout: bits [6:0] limit, bit 8 early-full mode, bit 9 early-empty mode, all other bits read 0. A write empties the queue and sets both queue pointers to 127. It takes precedence over a push or pop in the same cycle, and those are dropped.
- R7: The queue occupies addresses 127 down to the limit. A push stores `fifo_wdata` at the write pointer, then steps that pointer down, wrapping from the limit back to 127. A pop returns the oldest entry on `fifo_rdata`, with `fifo_rvalid`=1, in the following cycle. Pushed entries are also visible through the execution port.
- R8: Capacity is 128 minus the limit. In normal mode, full means count = capacity and empty means count = 0. In early-full mode, full means count >= capacity-1. In early-empty mode, empty means count <= 1. The flags reflect the state after each clock edge.
- R9: A push while `fifo_full`=1 and a pop while `fifo_empty`=1 are ignored: no entry is written, no pointer or count moves, and `fifo_rvalid` stays 0.
- R10: If a host store-window write and a push occur in the same cycle, the host write is taken and the push is ignored. A push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_en | input | 1 | Host access strobe |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_reg | input | 2 | Host register select |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_rvalid | output | 1 | Host read data valid |
| ex_rd | input | 1 | Execution read request |
| ex_addr | input | 7 | Execution read address |
| ex_data | output | 20 | Execution read entry |
| ex_valid | output | 1 | Execution read data valid |
| fifo_push | input | 1 | Queue push request |
| fifo_wdata | input | 20 | Queue push entry |
| fifo_pop | input | 1 | Queue pop request |
| fifo_rdata | output | 20 | Queue pop entry |
| fifo_rvalid | output | 1 | Queue pop data valid |
| fifo_full | output | 1 | Queue full flag |
| fifo_empty | output | 1 | Queue empty flag |

## Verification
The bench builds the block with its default 128-entry depth and a reset limit of 0x60. With that depth, a host stream through every location carries the pointer across its wrap from 127 to 0. The bench also reprograms the limit at random between 100 and 127. This reaches single-entry queues, where the early-full flag is always set, as well as queue-pointer wraps at the limit and back-to-back push and pop in both flag modes.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int WORD_W  = 16;
  localparam int CTRL_W  = 4;
  localparam int ENTRY_W = WORD_W + CTRL_W;
  localparam int FE_BIT  = 8;
  localparam int EE_BIT  = 9;

  typedef enum logic [1:0] {
    REG_STORE = 2'd0,
    REG_PTR   = 2'd1,
    REG_QCFG  = 2'd2,
    REG_NONE  = 2'd3
  } hreg_e;

  typedef enum logic [1:0] {
    SRC_WORD = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_REG  = 2'd2
  } rsrc_e;

  typedef struct packed {
    logic        s_bit;
    logic [2:0]  lvl;
    logic [15:0] word;
  } entry_t;
endpackage

// File: rtl/isb_mem.sv
module isb_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 128,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [W-1:0]      wd,
  input  logic [NRD-1:0]    re,
  input  logic [NRD*AW-1:0] ra,
  output logic [NRD*W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // one registered read port per consumer, read-before-write
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (re[g]) q <= mem[ra[g*AW +: AW]];
    end
    assign rd[g*W +: W] = q;
  end
endmodule

// File: rtl/isb_host_seq.sv
module isb_host_seq
  import isb_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_en,
  input  logic              hst_we,
  input  logic [1:0]        hst_reg,
  input  logic [WORD_W-1:0] hst_wdata,
  input  logic [AW-1:0]     cfg_limit,
  input  logic              cfg_fe,
  input  logic              cfg_ee,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [CTRL_W-1:0] mem_ctrl,
  output logic [AW-1:0]     ptr,
  output logic              phase,
  output logic              word_we,
  output logic              ctrl_we,
  output logic              store_re,
  output logic              cfg_we,
  output logic [WORD_W-1:0] hst_rdata,
  output logic              hst_rvalid
);
  hreg_e sel;
  logic  wr, rd, store_acc;
  rsrc_e rsrc_q;
  logic [WORD_W-1:0] shadow_q, ptr_view, cfg_view;

  assign sel       = hreg_e'(hst_reg);
  assign wr        = hst_en & hst_we;
  assign rd        = hst_en & ~hst_we;
  assign store_acc = hst_en & (sel == REG_STORE);
  assign word_we   = wr & (sel == REG_STORE) & ~phase;
  assign ctrl_we   = wr & (sel == REG_STORE) & phase;
  assign store_re  = rd & (sel == REG_STORE);
  assign cfg_we    = wr & (sel == REG_QCFG);

  always_comb begin
    ptr_view               = '0;
    ptr_view[AW-1:0]       = ptr;
    ptr_view[WORD_W-1]     = phase;
    cfg_view               = '0;
    cfg_view[AW-1:0]       = cfg_limit;
    cfg_view[FE_BIT]       = cfg_fe;
    cfg_view[EE_BIT]       = cfg_ee;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      phase      <= 1'b0;
      hst_rvalid <= 1'b0;
      rsrc_q     <= SRC_REG;
      shadow_q   <= '0;
    end else begin
      hst_rvalid <= rd;
      if (store_acc) begin
        phase <= ~phase;
        if (phase) ptr <= ptr + AW'(1);
      end else if (wr && sel == REG_PTR) begin
        ptr   <= hst_wdata[AW-1:0];
        phase <= 1'b0;
      end
      if (rd) begin
        case (sel)
          REG_STORE: rsrc_q <= phase ? SRC_CTRL : SRC_WORD;
          REG_PTR: begin
            rsrc_q   <= SRC_REG;
            shadow_q <= ptr_view;
          end
          REG_QCFG: begin
            rsrc_q   <= SRC_REG;
            shadow_q <= cfg_view;
          end
          default: begin
            rsrc_q   <= SRC_REG;
            shadow_q <= '0;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (rsrc_q)
      SRC_WORD: hst_rdata = mem_word;
      SRC_CTRL: hst_rdata = {{(WORD_W-CTRL_W){1'b0}}, mem_ctrl};
      default:  hst_rdata = shadow_q;
    endcase
  end
endmodule

// File: rtl/isb_fifo_ctl.sv
module isb_fifo_ctl #(
  parameter int DEPTH     = 128,
  parameter int LIMIT_RST = 96,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          blocked,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_lim,
  input  logic          cfg_fe,
  input  logic          cfg_ee,
  output logic [AW-1:0] limit,
  output logic          early_full,
  output logic          early_empty,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty,
  output logic          rvalid
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] lim_n, wp_n, rp_n;
  logic          fe_n, ee_n, full_n, empty_n;
  logic [AW:0]   cnt_n;
  int            cap_i, cnt_i;

  assign push_ok = push & ~full & ~blocked & ~cfg_we;
  assign pop_ok  = pop & ~empty & ~cfg_we;

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p,
                                               input logic [AW-1:0] lim);
    return (p == lim) ? TOP : p - AW'(1);
  endfunction

  always_comb begin
    lim_n = limit;
    fe_n  = early_full;
    ee_n  = early_empty;
    wp_n  = wr_ptr;
    rp_n  = rd_ptr;
    cnt_n = count;
    if (cfg_we) begin
      lim_n = cfg_lim;
      fe_n  = cfg_fe;
      ee_n  = cfg_ee;
      wp_n  = TOP;
      rp_n  = TOP;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = step_down(wr_ptr, limit);
      if (pop_ok)  rp_n = step_down(rd_ptr, limit);
      cnt_n = count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
    cap_i   = DEPTH - int'(lim_n);
    cnt_i   = int'(cnt_n);
    full_n  = fe_n ? (cnt_i >= cap_i - 1) : (cnt_i == cap_i);
    empty_n = ee_n ? (cnt_i <= 1) : (cnt_i == 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit       <= AW'(LIMIT_RST);
      early_full  <= 1'b0;
      early_empty <= 1'b0;
      wr_ptr      <= TOP;
      rd_ptr      <= TOP;
      count       <= '0;
      full        <= 1'b0;
      empty       <= 1'b1;
      rvalid      <= 1'b0;
    end else begin
      limit       <= lim_n;
      early_full  <= fe_n;
      early_empty <= ee_n;
      wr_ptr      <= wp_n;
      rd_ptr      <= rp_n;
      count       <= cnt_n;
      full        <= full_n;
      empty       <= empty_n;
      rvalid      <= pop_ok;
    end
  end
endmodule

// File: rtl/instr_store_buf.sv
module instr_store_buf
  import isb_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int LIMIT_RST = 96,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_en,
  input  logic               hst_we,
  input  logic [1:0]         hst_reg,
  input  logic [WORD_W-1:0]  hst_wdata,
  output logic [WORD_W-1:0]  hst_rdata,
  output logic               hst_rvalid,
  input  logic               ex_rd,
  input  logic [AW-1:0]      ex_addr,
  output logic [ENTRY_W-1:0] ex_data,
  output logic               ex_valid,
  input  logic               fifo_push,
  input  logic [ENTRY_W-1:0] fifo_wdata,
  input  logic               fifo_pop,
  output logic [ENTRY_W-1:0] fifo_rdata,
  output logic               fifo_rvalid,
  output logic               fifo_full,
  output logic               fifo_empty
);
  localparam int NRD = 3;

  logic [AW-1:0] host_ptr, fifo_limit, fifo_wp, fifo_rp;
  logic          host_phase, word_we, ctrl_we, store_re, cfg_we;
  logic          fe, ee, push_ok, pop_ok;
  logic [AW:0]   fifo_cnt;

  logic              dmem_we, cmem_we;
  logic [AW-1:0]     dmem_wa, cmem_wa;
  logic [WORD_W-1:0] dmem_wd;
  logic [CTRL_W-1:0] cmem_wd;
  logic [NRD*AW-1:0] rd_addr;
  logic [NRD-1:0]    rd_en;
  logic [NRD*WORD_W-1:0] dmem_rd;
  logic [NRD*CTRL_W-1:0] cmem_rd;
  entry_t            push_ent;

  assign push_ent = entry_t'(fifo_wdata);

  isb_host_seq #(.DEPTH(DEPTH)) u_host (
    .clk       (clk),
    .rst       (rst),
    .hst_en    (hst_en),
    .hst_we    (hst_we),
    .hst_reg   (hst_reg),
    .hst_wdata (hst_wdata),
    .cfg_limit (fifo_limit),
    .cfg_fe    (fe),
    .cfg_ee    (ee),
    .mem_word  (dmem_rd[0 +: WORD_W]),
    .mem_ctrl  (cmem_rd[0 +: CTRL_W]),
    .ptr       (host_ptr),
    .phase     (host_phase),
    .word_we   (word_we),
    .ctrl_we   (ctrl_we),
    .store_re  (store_re),
    .cfg_we    (cfg_we),
    .hst_rdata (hst_rdata),
    .hst_rvalid(hst_rvalid)
  );

  isb_fifo_ctl #(.DEPTH(DEPTH), .LIMIT_RST(LIMIT_RST)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (fifo_push),
    .pop        (fifo_pop),
    .blocked    (word_we | ctrl_we),
    .cfg_we     (cfg_we),
    .cfg_lim    (hst_wdata[AW-1:0]),
    .cfg_fe     (hst_wdata[FE_BIT]),
    .cfg_ee     (hst_wdata[EE_BIT]),
    .limit      (fifo_limit),
    .early_full (fe),
    .early_empty(ee),
    .wr_ptr     (fifo_wp),
    .rd_ptr     (fifo_rp),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .count      (fifo_cnt),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .rvalid     (fifo_rvalid)
  );

  // single write port per array: host half-writes win over queue pushes
  always_comb begin
    dmem_we = word_we | push_ok;
    dmem_wa = word_we ? host_ptr : fifo_wp;
    dmem_wd = word_we ? hst_wdata : push_ent.word;
    cmem_we = ctrl_we | push_ok;
    cmem_wa = ctrl_we ? host_ptr : fifo_wp;
    cmem_wd = ctrl_we ? hst_wdata[CTRL_W-1:0] : {push_ent.s_bit, push_ent.lvl};
  end

  // read port 0: host, 1: execution, 2: queue pop
  assign rd_addr = {fifo_rp, ex_addr, host_ptr};
  assign rd_en   = {pop_ok, ex_rd, store_re};

  isb_mem #(.W(WORD_W), .DEPTH(DEPTH), .NRD(NRD)) u_word_mem (
    .clk(clk), .we(dmem_we), .wa(dmem_wa), .wd(dmem_wd),
    .re(rd_en), .ra(rd_addr), .rd(dmem_rd)
  );

  isb_mem #(.W(CTRL_W), .DEPTH(DEPTH), .NRD(NRD)) u_ctrl_mem (
    .clk(clk), .we(cmem_we), .wa(cmem_wa), .wd(cmem_wd),
    .re(rd_en), .ra(rd_addr), .rd(cmem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) ex_valid <= 1'b0;
    else     ex_valid <= ex_rd;
  end

  assign ex_data    = {cmem_rd[CTRL_W +: CTRL_W],   dmem_rd[WORD_W +: WORD_W]};
  assign fifo_rdata = {cmem_rd[2*CTRL_W +: CTRL_W], dmem_rd[2*WORD_W +: WORD_W]};
endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          hst_en,
  input logic          hst_we,
  input logic [1:0]    hst_reg,
  input logic [AW-1:0] wlow,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [AW-1:0] host_ptr,
  input logic          host_phase,
  input logic [AW:0]   fifo_cnt,
  input logic [AW-1:0] fifo_limit
);
  logic cfg_wr;
  assign cfg_wr = hst_en && hst_we && hst_reg == 2'd2;

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (hst_en && hst_reg == 2'd0 && !host_phase) |=> $stable(host_ptr));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (hst_en && hst_reg == 2'd0 && host_phase) |=>
      (host_ptr == AW'($past(host_ptr) + AW'(1)) && !host_phase));

  assert_ptr_load_R5: assert property (@(posedge clk) disable iff (rst)
    (hst_en && hst_we && hst_reg == 2'd1) |=>
      (host_ptr == $past(wlow) && !host_phase));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && fifo_push && !fifo_pop && !cfg_wr) |=> $stable(fifo_cnt));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && fifo_pop && !fifo_push && !cfg_wr) |=> $stable(fifo_cnt));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_cnt) <= DEPTH - int'(fifo_limit));

  assert_cfg_clear_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (fifo_cnt == '0));
endmodule

bind instr_store_buf isb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hst_en     (hst_en),
  .hst_we     (hst_we),
  .hst_reg    (hst_reg),
  .wlow       (hst_wdata[AW-1:0]),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .host_ptr   (host_ptr),
  .host_phase (host_phase),
  .fifo_cnt   (fifo_cnt),
  .fifo_limit (fifo_limit)
);

// File: tb/sim_instr_store_buf.sv
module sim_instr_store_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_en = 0, hst_we = 0;
  logic [1:0]  hst_reg = 0;
  logic [15:0] hst_wdata = 0, hst_rdata;
  logic        hst_rvalid;
  logic        ex_rd = 0;
  logic [6:0]  ex_addr = 0;
  logic [19:0] ex_data;
  logic        ex_valid;
  logic        fifo_push = 0, fifo_pop = 0;
  logic [19:0] fifo_wdata = 0, fifo_rdata;
  logic        fifo_rvalid, fifo_full, fifo_empty;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [15:0] m_word [DEPTH];
  logic [3:0]  m_ctrl [DEPTH];
  int m_ptr = 0, m_lim = 96, m_cnt = 0, m_wp = 127, m_rp = 127;
  bit m_phase = 0, m_fe = 0, m_ee = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_store_buf u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit full_f(int c);
    int cap = DEPTH - m_lim;
    return m_fe ? (c >= cap - 1) : (c == cap);
  endfunction
  function automatic bit empty_f(int c);
    return m_ee ? (c <= 1) : (c == 0);
  endfunction
  function automatic int dn(int p);
    return (p == m_lim) ? DEPTH - 1 : p - 1;
  endfunction

  task automatic model_host(input logic [1:0] r, input bit w, input logic [15:0] d);
    case (r)
      2'd0: begin
        if (w) begin
          if (!m_phase) m_word[m_ptr] = d; else m_ctrl[m_ptr] = d[3:0];
        end
        if (m_phase) m_ptr = (m_ptr + 1) % DEPTH;
        m_phase = ~m_phase;
      end
      2'd1: if (w) begin m_ptr = int'(d[6:0]); m_phase = 0; end
      2'd2: if (w) begin
        m_lim = int'(d[6:0]); m_fe = d[8]; m_ee = d[9];
        m_cnt = 0; m_wp = DEPTH - 1; m_rp = DEPTH - 1;
      end
      default: ;
    endcase
  endtask

  task automatic hwrite(input logic [1:0] r, input logic [15:0] d);
    @(negedge clk);
    hst_en = 1; hst_we = 1; hst_reg = r; hst_wdata = d;
    @(negedge clk);
    hst_en = 0; hst_we = 0;
    model_host(r, 1'b1, d);
  endtask

  function automatic logic [15:0] host_exp(input logic [1:0] r);
    case (r)
      2'd0: return m_phase ? {12'h0, m_ctrl[m_ptr]} : m_word[m_ptr];
      2'd1: return {m_phase, 8'h00, 7'(m_ptr)};
      2'd2: return {6'h0, m_ee, m_fe, 1'b0, 7'(m_lim)};
      default: return 16'h0;
    endcase
  endfunction

  task automatic hread(input logic [1:0] r, input string tag);
    logic [15:0] e;
    e = host_exp(r);
    @(negedge clk);
    hst_en = 1; hst_we = 0; hst_reg = r;
    @(negedge clk);
    hst_en = 0;
    model_host(r, 1'b0, 16'h0);
    chk({tag, " rvalid"}, 32'(hst_rvalid), 32'd1);
    chk({tag, " rdata"}, 32'(hst_rdata), 32'(e));
  endtask

  task automatic exread(input int a, input string tag);
    @(negedge clk);
    ex_rd = 1; ex_addr = 7'(a);
    @(negedge clk);
    ex_rd = 0;
    chk({tag, " ex_valid"}, 32'(ex_valid), 32'd1);
    chk({tag, " ex_data"}, 32'(ex_data), 32'({m_ctrl[a], m_word[a]}));
  endtask

  task automatic qop(input bit ps, input bit pp, input logic [19:0] d);
    bit pok, qok;
    logic [19:0] e;
    pok = ps && !full_f(m_cnt);
    qok = pp && !empty_f(m_cnt);
    e = {m_ctrl[m_rp], m_word[m_rp]};
    @(negedge clk);
    fifo_push = ps; fifo_pop = pp; fifo_wdata = d;
    @(negedge clk);
    fifo_push = 0; fifo_pop = 0;
    if (pok) begin
      m_word[m_wp] = d[15:0]; m_ctrl[m_wp] = d[19:16];
      m_wp = dn(m_wp); m_cnt++;
    end
    if (qok) begin m_rp = dn(m_rp); m_cnt--; end
    chk("R9 pop accepted", 32'(fifo_rvalid), 32'(qok));
    if (qok) chk("R7 pop order", 32'(fifo_rdata), 32'(e));
    chk("R8 full flag", 32'(fifo_full), 32'(full_f(m_cnt)));
    chk("R8 empty flag", 32'(fifo_empty), 32'(empty_f(m_cnt)));
  endtask

  task automatic cfg(input int lim, input bit fe, input bit ee);
    logic [15:0] v;
    v = 16'h0; v[6:0] = 7'(lim); v[8] = fe; v[9] = ee;
    hwrite(2'd2, v);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 empty", 32'(fifo_empty), 32'd1);
    chk("R1 full", 32'(fifo_full), 32'd0);
    chk("R1 rvalid", 32'(hst_rvalid), 32'd0);
    chk("R1 ex_valid", 32'(ex_valid), 32'd0);
    hread(2'd1, "R1 pointer");
    hread(2'd2, "R1 queue control");

    // R4 stream every location, pointer wraps to 0
    for (int i = 0; i < DEPTH; i++) begin
      hwrite(2'd0, 16'($urandom));
      hwrite(2'd0, 16'($urandom));
    end
    hread(2'd1, "R4 pointer wrap");
    // R5 phase visible in pointer register
    hwrite(2'd0, 16'hBEEF);
    hread(2'd1, "R5 phase bit");
    hwrite(2'd1, 16'h0005);
    hread(2'd1, "R5 pointer load");
    // R4 host reads, both halves
    for (int i = 0; i < 12; i++) begin
      hwrite(2'd1, 16'($urandom));
      hread(2'd0, "R4 word half");
      hread(2'd1, "R4 hold after first half");
      hread(2'd0, "R4 control half");
      hread(2'd1, "R4 advance");
    end
    // R2 execution port
    for (int i = 0; i < 40; i++) exread(int'($urandom % DEPTH), "R2 entry");
    // R3 unused register
    hwrite(2'd3, 16'hFFFF);
    hread(2'd3, "R3 unused reads zero");
    hread(2'd1, "R3 pointer untouched");
    hread(2'd2, "R3 control untouched");

    // R6/R7/R9 small queue, normal flags
    cfg(124, 0, 0);
    hread(2'd2, "R6 control readback");
    for (int i = 0; i < 6; i++) qop(1, 0, 20'($urandom));
    exread(127, "R7 first push at top");
    exread(124, "R7 last slot at limit");
    for (int i = 0; i < 6; i++) qop(0, 1, 20'h0);
    // R6 control write empties queue
    for (int i = 0; i < 3; i++) qop(1, 0, 20'($urandom));
    cfg(120, 1, 1);
    qop(0, 1, 20'h0);
    // R8 random traffic under random configurations
    for (int k = 0; k < 6; k++) begin
      cfg(100 + int'($urandom % 28), bit'($urandom), bit'($urandom));
      for (int i = 0; i < 150; i++)
        qop(($urandom % 3) != 0, ($urandom % 2) != 0, 20'($urandom));
    end
    cfg(127, 1, 0);
    qop(1, 0, 20'h12345);
    cfg(127, 0, 0);
    qop(1, 0, 20'h2ABCD);
    qop(1, 0, 20'h3CCCC);
    qop(0, 1, 20'h0);

    // R10 host store write collides with a push
    cfg(110, 0, 0);
    hwrite(2'd1, 16'd20);
    @(negedge clk);
    hst_en = 1; hst_we = 1; hst_reg = 2'd0; hst_wdata = 16'h5A5A;
    fifo_push = 1; fifo_wdata = 20'hFFFFF;
    @(negedge clk);
    hst_en = 0; hst_we = 0; fifo_push = 0;
    model_host(2'd0, 1'b1, 16'h5A5A);
    chk("R10 push dropped", 32'(fifo_empty), 32'd1);
    exread(20, "R10 host write taken");
    // R10 push and pop together
    qop(1, 0, 20'h11111);
    qop(1, 1, 20'h22222);
    qop(0, 1, 20'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule